// File: doc/BRIEF.md
# TLB Access Rights and Fault Checker

This block sits after a TLB lookup in a processor's memory pipeline. It takes the looked-up entry, the kind of access being attempted, the current privilege level and the protection-ID context, and it decides three things. The first is which rights (read, write, execute) the access holds. The second is whether the access faults and with which cause. The third is the final physical address after absolute-to-physical space remapping.

A request is presented with a one-cycle strobe. The rights mask, the fault indication and the mapped address appear registered on the next cycle. They stay unchanged until the next strobe.

Privilege level 0 is the most privileged. The entry carries two privilege bounds, a rights type, an access identifier, and the dirty, break and reference flags. Storing the TLB and delivering the resulting exception both belong to other blocks.

Top module: `tlb_rights_check`

## Requirements
- R1: When `req_valid` is high at a rising edge, `out_valid` is high for exactly the following cycle, and `rights`, `fault_valid`, `fault_code` and `phys_addr` are updated at that same edge. When `fault_valid` is low, `fault_code` is 0. After reset, all outputs are 0.
- R2: `rights` is encoded with bit 0 = read, bit 1 = write and bit 2 = execute. Each right depends on the privilege level `priv` and the entry bounds `ent_pl1` and `ent_pl2`:
  - read is possible when `priv` <= `ent_pl1`;
  - write is possible when `priv` <= `ent_pl2`;
  - execute is possible when `ent_pl2` <= `priv` <= `ent_pl1`.
- R3: `ent_type` decides which of those possible rights are granted: 0 gives read, 1 gives read and write, 2 gives read and execute, 3 gives all three, and 4 to 7 give execute only.
- R4: A protection-ID match occurs when `pid_check_en` is 1, `ent_aid` is nonzero, and {`ent_aid`,1'b1} equals any of `pid0`..`pid3`. On a match, write is removed from the rights. If the access is also a write, it ends with fault code 2 and no further checks are made.
- R5: `acc_kind` is encoded as 0 = probe, 1 = read, 2 = write and 3 = execute. If the right that the access asks for is missing, the fault code is 3 for an execute access and 4 for a read or write access, and no further checks are made.
- R6: The flag checks are applied in this order, and a later fault code overrides an earlier one:
  - a clear dirty flag removes write, and with a write access gives code 5;
  - a set break flag removes write, and with a write access gives code 6;
  - a set reference flag leaves only execute, and with a read or write access gives code 7.
- R7: On a lookup miss (`hit` = 0, not physical mode), `rights` is 0 and `phys_addr` is 0. The fault code is 0 for an execute access and 1 for any other access.
- R8: In physical mode (`phys_mode` = 1), `rights` is 3'b111 and there is no fault. The address before mapping is `va`.
- R9: A probe access (`acc_kind` = 0) that hits never faults. Its rights reflect R2 to R4 only.
- R10: Wide mode (`addr_mode` = 2 or 3) maps the pre-mapping address A as follows:
  - if A[61:58] != 4'hF, bits 63:62 are cleared;
  - otherwise, if A[57:54] != 0, bits 63:62 are set;
  - otherwise the result is {4'hF, 6'b0, A[53:0]}.
- R11: Narrow mode (`addr_mode` = 1) maps the pre-mapping address A as follows:
  - if A[31:28] != 4'hF, the result is {32'h0, A[31:0]};
  - otherwise, if A[27:24] != 0, the result is {32'hFFFFFFFF, A[31:0]};
  - otherwise the result is {4'hF, 36'h0, A[23:0]}.
- R12: Legacy mode (`addr_mode` = 0) passes the pre-mapping address through unchanged.
- R13: On a hit, the pre-mapping address is `ent_pa` + (`va` - `ent_start`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | Access kind: 0 probe, 1 read, 2 write, 3 execute |
| priv | input | 2 | Current privilege level |
| phys_mode | input | 1 | Translation disabled |
| pid_check_en | input | 1 | Enable protection-ID comparison |
| addr_mode | input | 2 | 0 legacy, 1 narrow, 2/3 wide |
| pid0 | input | AID_W+1 | Protection-ID register 0 |
| pid1 | input | AID_W+1 | Protection-ID register 1 |
| pid2 | input | AID_W+1 | Protection-ID register 2 |
| pid3 | input | AID_W+1 | Protection-ID register 3 |
| va | input | 64 | Virtual address |
| hit | input | 1 | TLB lookup found an entry |
| ent_start | input | 64 | First virtual address covered by the entry |
| ent_pa | input | 64 | Physical base of the entry |
| ent_pl1 | input | 2 | Entry bound for read and execute |
| ent_pl2 | input | 2 | Entry bound for write and execute |
| ent_type | input | 3 | Entry rights type |
| ent_aid | input | AID_W | Entry access identifier |
| ent_dirty | input | 1 | Entry dirty flag |
| ent_break | input | 1 | Entry break flag |
| ent_ref | input | 1 | Entry reference-trap flag |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| rights | output | 3 | Granted rights {X,W,R} |
| fault_valid | output | 1 | A fault was raised |
| fault_code | output | 3 | Fault cause |
| phys_addr | output | 64 | Mapped physical address |

## Verification
Every result (rights, fault indication and code, and mapped address) is due exactly one clock edge after the strobe. `out_valid` pulses in that same cycle. The bench raises the strobe at a falling edge and lowers it at the next falling edge. It samples all outputs at that second falling edge, which lies half a period after the capturing rising edge. A near-exhaustive sweep covers every combination of privilege, bounds, type, access kind and flag states, and each result is compared with a model computed in the bench. Directed vectors then cover the protection-ID, miss, physical-mode and address-mapping cases.

// File: rtl/tlb_rights_check.sv
module tlb_rights_check #(
  parameter int AID_W = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          acc_kind,
  input  logic [1:0]          priv,
  input  logic                phys_mode,
  input  logic                pid_check_en,
  input  logic [1:0]          addr_mode,
  input  logic [AID_W:0]      pid0,
  input  logic [AID_W:0]      pid1,
  input  logic [AID_W:0]      pid2,
  input  logic [AID_W:0]      pid3,
  input  logic [63:0]         va,
  input  logic                hit,
  input  logic [63:0]         ent_start,
  input  logic [63:0]         ent_pa,
  input  logic [1:0]          ent_pl1,
  input  logic [1:0]          ent_pl2,
  input  logic [2:0]          ent_type,
  input  logic [AID_W-1:0]    ent_aid,
  input  logic                ent_dirty,
  input  logic                ent_break,
  input  logic                ent_ref,
  output logic                out_valid,
  output logic [2:0]          rights,
  output logic                fault_valid,
  output logic [2:0]          fault_code,
  output logic [63:0]         phys_addr
);
  localparam int PID_W = AID_W + 1;

  localparam logic [1:0] K_PROBE = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [1:0] K_EXEC  = 2'd3;

  localparam logic [2:0] F_IMISS = 3'd0;
  localparam logic [2:0] F_DMISS = 3'd1;
  localparam logic [2:0] F_PID   = 3'd2;
  localparam logic [2:0] F_IPROT = 3'd3;
  localparam logic [2:0] F_DACC  = 3'd4;
  localparam logic [2:0] F_DIRTY = 3'd5;
  localparam logic [2:0] F_BREAK = 3'd6;
  localparam logic [2:0] F_REF   = 3'd7;

  localparam logic [2:0] M_R = 3'b001;
  localparam logic [2:0] M_W = 3'b010;
  localparam logic [2:0] M_X = 3'b100;

  logic r_ok, w_ok, x_ok;
  assign r_ok = priv <= ent_pl1;
  assign w_ok = priv <= ent_pl2;
  assign x_ok = (ent_pl2 <= priv) && (priv <= ent_pl1);

  logic [2:0] type_rights;
  always_comb begin
    case (ent_type)
      3'd0:    type_rights = {1'b0, 1'b0, r_ok};
      3'd1:    type_rights = {1'b0, w_ok, r_ok};
      3'd2:    type_rights = {x_ok, 1'b0, r_ok};
      3'd3:    type_rights = {x_ok, w_ok, r_ok};
      default: type_rights = {x_ok, 1'b0, 1'b0};
    endcase
  end

  logic [PID_W-1:0] pid_key;
  logic             pid_hit;
  assign pid_key = {ent_aid, 1'b1};
  assign pid_hit = pid_check_en && (ent_aid != '0) &&
                   ((pid_key == pid0) || (pid_key == pid1) ||
                    (pid_key == pid2) || (pid_key == pid3));

  logic [2:0] need;
  always_comb begin
    case (acc_kind)
      K_READ:  need = M_R;
      K_WRITE: need = M_W;
      K_EXEC:  need = M_X;
      default: need = 3'b000;
    endcase
  end

  logic [2:0]  nx_rights;
  logic        nx_fv;
  logic [2:0]  nx_fc;
  logic [63:0] pre_addr;

  always_comb begin
    nx_rights = 3'b000;
    nx_fv     = 1'b0;
    nx_fc     = 3'd0;
    pre_addr  = 64'd0;
    if (phys_mode) begin
      nx_rights = 3'b111;
      pre_addr  = va;
    end else if (!hit) begin
      nx_fv = 1'b1;
      nx_fc = (acc_kind == K_EXEC) ? F_IMISS : F_DMISS;
    end else begin
      pre_addr  = ent_pa + (va - ent_start);
      nx_rights = pid_hit ? (type_rights & ~M_W) : type_rights;
      if (pid_hit && acc_kind == K_WRITE) begin
        nx_fv = 1'b1;
        nx_fc = F_PID;
      end else if (acc_kind == K_PROBE) begin
        nx_fv = 1'b0;
      end else if ((nx_rights & need) == 3'b000) begin
        nx_fv = 1'b1;
        nx_fc = (acc_kind == K_EXEC) ? F_IPROT : F_DACC;
      end else begin
        if (!ent_dirty) begin
          if (acc_kind == K_WRITE) begin
            nx_fv = 1'b1;
            nx_fc = F_DIRTY;
          end
          nx_rights = nx_rights & ~M_W;
        end
        if (ent_break) begin
          if (acc_kind == K_WRITE) begin
            nx_fv = 1'b1;
            nx_fc = F_BREAK;
          end
          nx_rights = nx_rights & ~M_W;
        end
        if (ent_ref) begin
          if (acc_kind != K_EXEC) begin
            nx_fv = 1'b1;
            nx_fc = F_REF;
          end
          nx_rights = nx_rights & M_X;
        end
      end
    end
  end

  logic [63:0] mapped;
  always_comb begin
    mapped = pre_addr;
    if (addr_mode == 2'd1) begin
      if (pre_addr[31:28] != 4'hF)
        mapped = {32'h0, pre_addr[31:0]};
      else if (pre_addr[27:24] != 4'h0)
        mapped = {32'hFFFF_FFFF, pre_addr[31:0]};
      else
        mapped = {4'hF, 36'h0, pre_addr[23:0]};
    end else if (addr_mode[1]) begin
      if (pre_addr[61:58] != 4'hF)
        mapped = {2'b00, pre_addr[61:0]};
      else if (pre_addr[57:54] != 4'h0)
        mapped = {2'b11, pre_addr[61:0]};
      else
        mapped = {4'hF, 6'h0, pre_addr[53:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      rights      <= 3'b000;
      fault_valid <= 1'b0;
      fault_code  <= 3'd0;
      phys_addr   <= 64'd0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        rights      <= nx_rights;
        fault_valid <= nx_fv;
        fault_code  <= nx_fc;
        phys_addr   <= mapped;
      end
    end
  end
endmodule

// File: rtl/tlb_rights_check_sva.sv
module tlb_rights_check_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [1:0]  acc_kind,
  input logic        phys_mode,
  input logic        hit,
  input logic [1:0]  addr_mode,
  input logic [63:0] va,
  input logic        out_valid,
  input logic [2:0]  rights,
  input logic        fault_valid,
  input logic [2:0]  fault_code,
  input logic [63:0] phys_addr
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R1
  AST_CODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid |-> fault_code == 3'd0); // R1
  AST_PHYS_ALL_RIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && phys_mode) |=> (rights == 3'b111 && !fault_valid)); // R8
  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !phys_mode && !hit) |=>
      (fault_valid && rights == 3'b000 && phys_addr == 64'd0 &&
       fault_code == (($past(acc_kind) == 2'd3) ? 3'd0 : 3'd1))); // R7
  AST_PROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !phys_mode && hit && acc_kind == 2'd0) |=> !fault_valid); // R9
  AST_REF_EXEC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && fault_code == 3'd7) |-> rights[1:0] == 2'b00); // R6
  AST_LEGACY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && phys_mode && addr_mode == 2'd0) |=> phys_addr == $past(va)); // R12
endmodule

bind tlb_rights_check tlb_rights_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
  .phys_mode(phys_mode), .hit(hit), .addr_mode(addr_mode), .va(va),
  .out_valid(out_valid), .rights(rights), .fault_valid(fault_valid),
  .fault_code(fault_code), .phys_addr(phys_addr)
);

// File: tb/tb_tlb_rights_check.sv
`timescale 1ns/1ps
module tb_tlb_rights_check;
  localparam int AID_W = 31;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0;
  logic [1:0]  acc_kind = 0, priv = 0, addr_mode = 0;
  logic        phys_mode = 0, pid_check_en = 0, hit = 0;
  logic [AID_W:0] pid0 = 0, pid1 = 0, pid2 = 0, pid3 = 0;
  logic [63:0] va = 0, ent_start = 0, ent_pa = 0;
  logic [1:0]  ent_pl1 = 0, ent_pl2 = 0;
  logic [2:0]  ent_type = 0;
  logic [AID_W-1:0] ent_aid = 0;
  logic        ent_dirty = 0, ent_break = 0, ent_ref = 0;
  logic        out_valid, fault_valid;
  logic [2:0]  rights, fault_code;
  logic [63:0] phys_addr;

  tlb_rights_check #(.AID_W(AID_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .priv(priv), .phys_mode(phys_mode), .pid_check_en(pid_check_en),
    .addr_mode(addr_mode), .pid0(pid0), .pid1(pid1), .pid2(pid2), .pid3(pid3),
    .va(va), .hit(hit), .ent_start(ent_start), .ent_pa(ent_pa),
    .ent_pl1(ent_pl1), .ent_pl2(ent_pl2), .ent_type(ent_type),
    .ent_aid(ent_aid), .ent_dirty(ent_dirty), .ent_break(ent_break),
    .ent_ref(ent_ref), .out_valid(out_valid), .rights(rights),
    .fault_valid(fault_valid), .fault_code(fault_code), .phys_addr(phys_addr)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Model from R2..R6, R9: returns {rights[2:0], fault_valid, code[2:0]}
  function automatic logic [6:0] model(input int kind, input int pv, input int p1,
                                       input int p2, input int ty, input bit d,
                                       input bit b, input bit t, input bit pidm);
    bit rd, wr, ex, f;
    int code;
    rd = (pv <= p1) && (ty < 4);
    wr = (pv <= p2) && (ty == 1 || ty == 3) && !pidm;
    ex = (p2 <= pv) && (pv <= p1) && (ty >= 2);
    f = 0; code = 0;
    if (pidm && kind == 2) begin f = 1; code = 2; end
    else if (kind == 0) begin end
    else if ((kind == 1 && !rd) || (kind == 2 && !wr) || (kind == 3 && !ex)) begin
      f = 1; code = (kind == 3) ? 3 : 4;
    end else begin
      if (!d) begin wr = 0; if (kind == 2) begin f = 1; code = 5; end end
      if (b)  begin wr = 0; if (kind == 2) begin f = 1; code = 6; end end
      if (t)  begin rd = 0; wr = 0; if (kind != 3) begin f = 1; code = 7; end end
    end
    return {ex, wr, rd, f, code[2:0]};
  endfunction

  // Model of R10..R12
  function automatic logic [63:0] map_model(input int mode, input logic [63:0] a);
    logic [63:0] hi_mask;
    if (mode == 0) return a;
    if (mode == 1) begin
      if ((a >> 28) % 16 != 15) return a & 64'h0000_0000_FFFF_FFFF;
      if ((a >> 24) % 16 != 0)  return a | 64'hFFFF_FFFF_0000_0000;
      return (a % (64'd1 << 24)) + 64'hF000_0000_0000_0000;
    end
    hi_mask = 64'hC000_0000_0000_0000;
    if ((a >> 58) % 16 != 15) return a & ~hi_mask;
    if ((a >> 54) % 16 != 0)  return a | hi_mask;
    return (a % (64'd1 << 54)) + 64'hF000_0000_0000_0000;
  endfunction

  task automatic fire();
    @(negedge clk) req_valid = 1;
    @(negedge clk) req_valid = 0;
  endtask

  task automatic chk_res(input string tag, input logic [6:0] exp);
    checks++;
    if (!out_valid || {rights, fault_valid, fault_code} !== exp) begin
      failures++;
      $display("FAIL %s: valid=%0b rights=%b fv=%0b code=%0d expected rights=%b fv=%0b code=%0d",
               tag, out_valid, rights, fault_valid, fault_code,
               exp[6:4], exp[3], exp[2:0]);
    end
  endtask

  task automatic chk_addr(input string tag, input logic [63:0] exp);
    checks++;
    if (phys_addr !== exp) begin
      failures++;
      $display("FAIL %s: addr=%h expected %h", tag, phys_addr, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] tv[9];
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if (out_valid || rights != 0 || fault_valid || fault_code != 0 || phys_addr != 0) begin
      failures++;
      $display("FAIL R1 reset: valid=%0b rights=%b fv=%0b code=%0d addr=%h expected all zero",
               out_valid, rights, fault_valid, fault_code, phys_addr);
    end
    rst_n = 1;
    @(negedge clk);
    @(negedge clk);
    checks++;
    if (out_valid) begin
      failures++;
      $display("FAIL R1 idle: out_valid=1 expected 0");
    end

    // Sweep R2 R3 R5 R6 R9
    hit = 1; phys_mode = 0; addr_mode = 0;
    for (int k = 0; k < 4; k++)
      for (int pv = 0; pv < 4; pv++)
        for (int p1 = 0; p1 < 4; p1++)
          for (int p2 = 0; p2 < 4; p2++)
            for (int ty = 0; ty < 8; ty++)
              for (int f = 0; f < 8; f++) begin
                acc_kind = 2'(k); priv = 2'(pv); ent_pl1 = 2'(p1); ent_pl2 = 2'(p2);
                ent_type = 3'(ty); ent_dirty = f[0]; ent_break = f[1]; ent_ref = f[2];
                fire();
                chk_res("R2/R3/R5/R6/R9 sweep",
                        model(k, pv, p1, p2, ty, f[0], f[1], f[2], 0));
                checks++;
                if (out_valid !== 1'b1) begin
                  failures++;
                  $display("FAIL R1 latency: out_valid=%0b expected 1", out_valid);
                end
              end

    // R4 protection-ID
    priv = 0; ent_pl1 = 3; ent_pl2 = 3; ent_type = 3; ent_dirty = 1; ent_break = 0; ent_ref = 0;
    ent_aid = 31'd5; pid_check_en = 1; pid2 = 32'd11;
    for (int k = 0; k < 4; k++) begin
      acc_kind = 2'(k);
      fire();
      chk_res("R4 pid match", model(k, 0, 3, 3, 3, 1, 0, 0, 1));
    end
    pid2 = 0; pid3 = 32'd11;
    acc_kind = 2; fire();
    chk_res("R4 pid match reg3", model(2, 0, 3, 3, 3, 1, 0, 0, 1));
    pid3 = 32'd10; acc_kind = 2; fire();
    chk_res("R4 low bit mismatch", model(2, 0, 3, 3, 3, 1, 0, 0, 0));
    pid3 = 32'd11; pid_check_en = 0; fire();
    chk_res("R4 check disabled", model(2, 0, 3, 3, 3, 1, 0, 0, 0));
    pid_check_en = 1; ent_aid = 0; pid0 = 32'd1; fire();
    chk_res("R4 public id", model(2, 0, 3, 3, 3, 1, 0, 0, 0));
    pid0 = 0; pid3 = 0; pid_check_en = 0;

    // R7 miss
    hit = 0; va = 64'h1234_5678; addr_mode = 2;
    for (int k = 0; k < 4; k++) begin
      acc_kind = 2'(k); fire();
      chk_res("R7 miss", {3'b000, 1'b1, (k == 3) ? 3'd0 : 3'd1});
      chk_addr("R7 miss addr", 64'd0);
    end

    // R8 physical mode, R10 R11 R12 mapping
    phys_mode = 1; acc_kind = 2;
    tv[0] = 64'hC123_4567_89AB_CDEF; tv[1] = 64'h3F40_0000_0000_1234;
    tv[2] = 64'h3C00_1234_5678_9ABC; tv[3] = 64'hFC3F_FFFF_FFFF_FFFF;
    tv[4] = 64'hDEAD_BEEF_1234_5678; tv[5] = 64'hDEAD_BEEF_F100_0000;
    tv[6] = 64'hDEAD_BEEF_F0AB_CDEF; tv[7] = 64'h0000_0000_FFFF_FFFF;
    tv[8] = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 9; i++) begin
        addr_mode = 2'(m); va = tv[i]; fire();
        chk_res("R8 phys rights", {3'b111, 1'b0, 3'd0});
        chk_addr(m == 0 ? "R12 legacy" : (m == 1 ? "R11 narrow" : "R10 wide"),
                 map_model(m, tv[i]));
      end

    // R13 translation then mapping
    phys_mode = 0; hit = 1; acc_kind = 1; ent_type = 0; ent_ref = 0;
    ent_start = 64'h0000_0040_0000_0000; ent_pa = 64'h0000_0000_0123_0000;
    va = 64'h0000_0040_0000_5A5C;
    for (int m = 0; m < 3; m++) begin
      addr_mode = 2'(m); fire();
      chk_addr("R13 translate", map_model(m, 64'h0000_0000_0123_5A5C));
    end
    ent_pa = 64'h0000_0000_F000_0000; addr_mode = 1; fire();
    chk_addr("R13 translate firmware", map_model(1, 64'h0000_0000_F000_5A5C));

    finish_run();
  end
endmodule